// File: doc/BRIEF.md
# GPIO port with per-pin interrupt detection

This block is one general-purpose I/O port of up to sixteen pins, reached through a simple word-addressed 32-bit register bus. Software drives pins through an output latch and picks, per pin, whether it drives or only listens. A direction bit of 1 makes the pin drive; 0 leaves it as an input. The current pin levels can be read back after they have passed through a two-stage synchroniser.

Every pin also has its own interrupt detector. An enable bit turns it on. A three-bit mode code chooses falling edge, rising edge, both edges, low level or high level. A detection sets a sticky pending flag. Software acknowledges a pending flag by writing ones to a clear word. Each pin can be masked through two words: one sets mask bits and the other clears them. The single `irq` output is high while any pending flag is both enabled and unmasked. A soft-reset word holds the whole port at its reset state while its low bit is 1.

Word map, by word index on `bus_addr`:
- 0: enable.
- 1: pending status.
- 2: masked view.
- 3: acknowledge.
- 4: mask set.
- 5: mask clear.
- 6: output latch.
- 7: pin input.
- 8: direction.
- 9: mode word for pins 0-7.
- 10: mode word for pins 8-15.
- 11: reserved.
- 12: soft reset.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, word 4 (mask) reads all ones in the low NPIN bits, every other word reads 0, `pin_out` and `pin_oe` are 0, and `irq` is low.
- R2: Word 6 (output latch) and word 8 (direction) are read/write over the low NPIN bits, with upper bits reading 0. Word 6 drives `pin_out`. Word 8 drives `pin_oe`, where 1 means the pin is an output.
- R3: Word 7 returns `pin_in` through a two-flop synchroniser. A level applied before clock edge k is readable after edge k+1 and is not yet visible after edge k.
- R4: Each pin has a 3-bit mode code in a 4-bit slot. Pin i below 8 sits at bits 4*i of word 9. Pin i of 8 or above sits at bits 4*(i-8) of word 10. Bit 3 of every slot reads 0. The codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 either edge. Codes 5, 6 and 7 detect nothing.
- R5: A pin's pending bit (word 1) is set when the pin is enabled and its mode condition holds on the synchronised input. It then stays set until acknowledged or reset. A disabled pin never sets its pending bit.
- R6: Writing 1s to word 3 clears the matching pending bits, and 0 bits have no effect. If a detection happens in the same cycle, the set wins, so a level condition that persists re-sets the bit at once.
- R7: Writing 1s to word 4 sets mask bits, and writing 1s to word 5 clears them. Zero bits leave the mask unchanged. Word 4 reads the mask.
- R8: `irq` is the OR over pins of pending AND enable AND NOT mask. Word 2 reads that same per-pin masked vector.
- R9: Word 0 (enable) is a plain read/write register over the low NPIN bits.
- R10: While bit 0 of word 12 is 1, every other register is held at its R1 value. After a write of 0 to word 12 the port runs again from those values. Word 12 reads back its bit 0.
- R11: Words 3, 5 and 11 and unused indexes 13-15 read 0. Writes to words 1, 2 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | NPIN | Pin levels from the pads |
| pin_out | output | NPIN | Output latch value |
| pin_oe | output | NPIN | Drive enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Random trials pick, per pin, an enable bit, a mode code (including the three codes that detect nothing) and a mask bit. Each trial applies a random old pin level, acknowledges everything, then applies a random new level.

The expected pending vector is built from the old-to-new transition for edge codes. For level codes it is built from old or new, because a persisting level re-arms after the acknowledge. This separates edge from level handling, rising from falling, and the enable gate from the mask gate.

Directed cases cover:
- synchroniser latency;
- slot packing of the mode words;
- partial acknowledges;
- set-wins-over-clear for a held level;
- the two mask words;
- the soft-reset hold.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;
    localparam int MAXPIN = 16;
    localparam int SLOT_W = 4;
    localparam int MODE_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RG_ENABLE  = 4'd0,
        RG_PEND    = 4'd1,
        RG_VIEW    = 4'd2,
        RG_ACK     = 4'd3,
        RG_MSET    = 4'd4,
        RG_MCLR    = 4'd5,
        RG_DOUT    = 4'd6,
        RG_DIN     = 4'd7,
        RG_DIR     = 4'd8,
        RG_MODE_LO = 4'd9,
        RG_MODE_HI = 4'd10,
        RG_RSVD    = 4'd11,
        RG_SOFT    = 4'd12
    } reg_idx_e;

    typedef enum logic [MODE_W-1:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_mode_e;

    // Detection condition from the current and previous synchronised samples.
    function automatic logic trig_hit(logic [MODE_W-1:0] code, logic cur, logic prv);
        case (code)
            TRIG_FALL: return !cur && prv;
            TRIG_RISE: return cur && !prv;
            TRIG_LOW:  return !cur;
            TRIG_HIGH: return cur;
            TRIG_BOTH: return cur ^ prv;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prv_o
);
    logic [W-1:0] meta_q, cur_q, prv_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            meta_q <= '0;
            cur_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= raw_i;
            cur_q  <= meta_q;
            prv_q  <= cur_q;
        end
    end

    assign cur_o = cur_q;
    assign prv_o = prv_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kill_i,
    input  logic              en_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cur_i,
    input  logic              prv_i,
    input  logic              ack_i,
    output logic              st_o
);
    logic st_q;
    logic hit;

    assign hit = en_i && trig_hit(mode_i, cur_i, prv_i);

    always_ff @(posedge clk) begin
        if (rst || kill_i) st_q <= 1'b0;
        else               st_q <= (st_q && !ack_i) || hit;
    end

    assign st_o = st_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_q && !ack_i && !kill_i) |=> st_q); // R5
    AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!st_q && !en_i) |=> !st_q); // R5
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        (en_i && mode_i == 3'd1 && cur_i && !prv_i && !kill_i) |=> st_q); // R4
    AST_LEVEL_WINS_ACK: assert property (@(posedge clk) disable iff (rst)
        (en_i && mode_i == 3'd3 && cur_i && ack_i && !kill_i) |=> st_q); // R6
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    localparam int PADW = BUS_W - NPIN;
    localparam int HALF = MAXPIN / 2;

    logic [NPIN-1:0]   en_q, mask_q, dout_q, dir_q;
    logic [MODE_W-1:0] mode_q [MAXPIN];
    logic              soft_q;
    logic [NPIN-1:0]   cur_s, prv_s, pend, view, ack_v;
    logic [BUS_W-1:0]  mode_lo, mode_hi;
    logic              wr;
    logic              unused_wbits;

    assign wr           = bus_en && bus_we;
    assign unused_wbits = ^bus_wdata;
    assign ack_v        = (wr && bus_addr == RG_ACK) ? bus_wdata[NPIN-1:0] : '0;

    gpio_pin_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .clr   (rst || soft_q),
        .raw_i (pin_in),
        .cur_o (cur_s),
        .prv_o (prv_s)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_cell
        gpio_irq_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .kill_i (soft_q),
            .en_i   (en_q[g]),
            .mode_i (mode_q[g]),
            .cur_i  (cur_s[g]),
            .prv_i  (prv_s[g]),
            .ack_i  (ack_v[g]),
            .st_o   (pend[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                                soft_q <= 1'b0;
        else if (wr && bus_addr == RG_SOFT)     soft_q <= bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst || soft_q) begin
            en_q   <= '0;
            mask_q <= '1;
            dout_q <= '0;
            dir_q  <= '0;
            for (int i = 0; i < MAXPIN; i++) mode_q[i] <= '0;
        end else if (wr) begin
            case (bus_addr)
                RG_ENABLE: en_q   <= bus_wdata[NPIN-1:0];
                RG_MSET:   mask_q <= mask_q | bus_wdata[NPIN-1:0];
                RG_MCLR:   mask_q <= mask_q & ~bus_wdata[NPIN-1:0];
                RG_DOUT:   dout_q <= bus_wdata[NPIN-1:0];
                RG_DIR:    dir_q  <= bus_wdata[NPIN-1:0];
                RG_MODE_LO: begin
                    for (int i = 0; i < HALF; i++)
                        if (i < NPIN) mode_q[i] <= bus_wdata[SLOT_W*i +: MODE_W];
                end
                RG_MODE_HI: begin
                    for (int i = 0; i < HALF; i++)
                        if (i + HALF < NPIN) mode_q[i+HALF] <= bus_wdata[SLOT_W*i +: MODE_W];
                end
                default: ;
            endcase
        end
    end

    assign view    = pend & en_q & ~mask_q;
    assign irq     = |view;
    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

    always_comb begin
        mode_lo = '0;
        mode_hi = '0;
        for (int i = 0; i < HALF; i++) begin
            mode_lo[SLOT_W*i +: MODE_W] = mode_q[i];
            mode_hi[SLOT_W*i +: MODE_W] = mode_q[i+HALF];
        end
    end

    always_comb begin
        case (bus_addr)
            RG_ENABLE:  bus_rdata = {{PADW{1'b0}}, en_q};
            RG_PEND:    bus_rdata = {{PADW{1'b0}}, pend};
            RG_VIEW:    bus_rdata = {{PADW{1'b0}}, view};
            RG_MSET:    bus_rdata = {{PADW{1'b0}}, mask_q};
            RG_DOUT:    bus_rdata = {{PADW{1'b0}}, dout_q};
            RG_DIN:     bus_rdata = {{PADW{1'b0}}, cur_s};
            RG_DIR:     bus_rdata = {{PADW{1'b0}}, dir_q};
            RG_MODE_LO: bus_rdata = mode_lo;
            RG_MODE_HI: bus_rdata = mode_hi;
            RG_SOFT:    bus_rdata = {{(BUS_W-1){1'b0}}, soft_q};
            default:    bus_rdata = '0;
        endcase
    end

    AST_MASK_CLR_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == RG_MCLR && bus_wdata[0] && !soft_q) |=> !mask_q[0]); // R7
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(wr && (bus_addr == RG_MSET || bus_addr == RG_MCLR)) && !soft_q) |=> $stable(mask_q)); // R7
    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == RG_ACK || bus_addr == RG_MCLR) |-> bus_rdata == '0); // R11
    AST_SOFT_QUIET: assert property (@(posedge clk) disable iff (rst)
        soft_q |=> (!irq && pin_oe == '0)); // R10
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq); // R8
endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;
    localparam int NPIN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out, pin_oe;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    gpio_irq_port #(.NPIN(NPIN)) u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
        #0.5;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected pending bit after: acknowledge while pin is at o, then pin moves to n.
    function automatic logic exp_hit(logic [2:0] m, logic o, logic n);
        case (m)
            3'd0: return o && !n;
            3'd1: return !o && n;
            3'd2: return !o || !n;
            3'd3: return o || n;
            3'd4: return o != n;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] pack_modes(logic [2:0] m [NPIN], int base);
        logic [31:0] r = '0;
        for (int i = 0; i < 8; i++) r[4*i +: 3] = m[base+i];
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [2:0]  m [NPIN];
        logic [15:0] en, mk, o, n, ex;
        void'($urandom(32'd1357));

        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], d);
            chk("R1 reset word", d, (a == 4) ? 32'h0000FFFF : 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 pin_oe", {16'b0, pin_oe}, 32'h0);

        // R2 output latch / direction
        wr(4'd6, 32'hFFFF_A5C3);
        wr(4'd8, 32'h1234_0F0F);
        rd(4'd6, d); chk("R2 dout read", d, 32'h0000A5C3);
        rd(4'd8, d); chk("R2 dir read", d, 32'h00000F0F);
        chk("R2 pin_out", {16'b0, pin_out}, 32'h0000A5C3);
        chk("R2 pin_oe", {16'b0, pin_oe}, 32'h00000F0F);

        // R3 synchroniser latency
        @(negedge clk); pin_in = 16'h9C31;
        @(negedge clk); rd(4'd7, d); chk("R3 not yet visible", d, 32'h0);
        @(negedge clk); rd(4'd7, d); chk("R3 visible after two edges", d, 32'h00009C31);
        wr(4'd7, 32'h0); rd(4'd7, d); chk("R11 input write ignored", d, 32'h00009C31);
        pin_in = '0; wait_cyc(4);

        // R4 slot packing
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, d); chk("R4 mode lo slot bits", d, 32'h77777777);
        wr(4'd10, 32'h0043_2108);
        rd(4'd10, d); chk("R4 mode hi slot bits", d, 32'h00432100);

        // R9 enable read/write
        wr(4'd0, 32'hABCD_1234);
        rd(4'd0, d); chk("R9 enable rw", d, 32'h00001234);

        // R5 R6 R7 R8 random trials
        for (int t = 0; t < 60; t++) begin
            en = 16'($urandom); mk = 16'($urandom);
            o = 16'($urandom); n = 16'($urandom);
            for (int i = 0; i < NPIN; i++) m[i] = 3'($urandom);
            wr(4'd0, {16'b0, en});
            wr(4'd9, pack_modes(m, 0));
            wr(4'd10, pack_modes(m, 8));
            wr(4'd5, 32'h0000FFFF);
            wr(4'd4, {16'b0, mk});
            pin_in = o; wait_cyc(4);
            wr(4'd3, 32'h0000FFFF);
            pin_in = n; wait_cyc(4);
            for (int i = 0; i < NPIN; i++) ex[i] = en[i] && exp_hit(m[i], o[i], n[i]);
            rd(4'd1, d); chk("R5 pending vector", d, {16'b0, ex});
            rd(4'd2, d); chk("R8 masked view", d, {16'b0, ex & ~mk});
            chk("R8 irq", {31'b0, irq}, {31'b0, |(ex & ~mk)});
            rd(4'd4, d); chk("R7 mask read", d, {16'b0, mk});
        end

        // R6 partial acknowledge, R7 set/clear words, R8 masking
        pin_in = '0;
        wr(4'd0, 32'h0000FFFF);
        wr(4'd9, 32'h11111111);
        wr(4'd10, 32'h11111111);
        wr(4'd4, 32'h0000FFFF);
        wait_cyc(4);
        wr(4'd3, 32'h0000FFFF);
        pin_in = 16'hFFFF; wait_cyc(4);
        rd(4'd1, d); chk("R5 rising all", d, 32'h0000FFFF);
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(4'd3, 32'h000000FF);
        rd(4'd1, d); chk("R6 partial ack", d, 32'h0000FF00);
        wr(4'd5, 32'h00000200);
        rd(4'd4, d); chk("R7 mask clear bit 9", d, 32'h0000FDFF);
        rd(4'd5, d); chk("R11 mask clear reads 0", d, 32'h0);
        rd(4'd2, d); chk("R8 view one pin", d, 32'h00000200);
        chk("R8 irq up", {31'b0, irq}, 32'h1);
        wr(4'd1, 32'h0); rd(4'd1, d); chk("R11 status write ignored", d, 32'h0000FF00);
        wr(4'd4, 32'h00000200);
        chk("R7 mask set again irq", {31'b0, irq}, 32'h0);

        // R6 held level re-sets immediately
        wr(4'd9, 32'h11111113);
        wr(4'd3, 32'h00000001);
        rd(4'd1, d); chk("R6 level set wins", d & 32'h1, 32'h1);
        // R4 invalid code detects nothing
        wr(4'd9, 32'h11111115);
        wr(4'd3, 32'h00000001);
        pin_in = 16'hFFFE; wait_cyc(4);
        rd(4'd1, d); chk("R4 code 5 no detect", d & 32'h1, 32'h0);
        rd(4'd11, d); chk("R11 reserved", d, 32'h0);
        rd(4'd14, d); chk("R11 unused index", d, 32'h0);

        // R10 soft reset
        wr(4'd6, 32'h0000BEEF);
        wr(4'd12, 32'h1);
        rd(4'd12, d); chk("R10 soft readback", d, 32'h1);
        wr(4'd0, 32'h0000FFFF);
        rd(4'd0, d); chk("R10 held enable", d, 32'h0);
        wr(4'd12, 32'h0);
        rd(4'd0, d); chk("R10 enable reset", d, 32'h0);
        rd(4'd4, d); chk("R10 mask reset", d, 32'h0000FFFF);
        rd(4'd6, d); chk("R10 dout reset", d, 32'h0);
        rd(4'd1, d); chk("R10 pending reset", d, 32'h0);
        rd(4'd9, d); chk("R10 mode reset", d, 32'h0);
        chk("R10 irq", {31'b0, irq}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule